// File: doc/BRIEF.md
# Decimal Complement Subtractor

This block subtracts one unsigned packed-BCD integer from another. It does not use a borrow chain. It adds a complement of the subtrahend to the minuend and then corrects the sum. A static mode input selects the method:

- **Nines' mode:** uses the nines' complement. A carry out of the top digit is added back at the bottom (end-around carry).
- **Tens' mode:** uses the tens' complement. A carry out of the top digit is dropped.

In both modes, a sum with no top carry is a negative result. The block then complements that sum again to get the magnitude. The outputs are a packed-BCD magnitude, a sign flag and a flag for illegal input digits. A request is presented with `in_valid`. The result is registered once and appears with `out_valid` one clock later.

Top module: `dec_comp_sub`

## Requirements
- R1: With `mode`=0 (nines' method) and minuend ≥ subtrahend, the result is the difference with `neg_o`=0. For example, 1234 − 1000 gives magnitude 0234.
- R2: With `mode`=0 and minuend < subtrahend, `neg_o`=1 and the magnitude is the absolute difference. For example, 1234 − 3000 gives 1766.
- R3: With `mode`=1 (tens' method) and minuend ≥ subtrahend, the result is the difference with `neg_o`=0.
- R4: With `mode`=1 and minuend < subtrahend, `neg_o`=1 and the magnitude is the absolute difference.
- R5: Equal operands give magnitude 0 with `neg_o`=0 in both modes. More generally, a zero magnitude is never flagged negative.
- R6: `bad_o` is 1 when any 4-bit digit of either operand lies in 1010..1111. Otherwise it is 0. When `bad_o`=1, the magnitude and sign are don't-care.
- R7: `out_valid` in a cycle equals `in_valid` of the previous cycle. Results are captured only when `in_valid`=1 and are held otherwise.
- R8: After a synchronous active-low reset, `out_valid`, `diff_o`, `neg_o` and `bad_o` are all 0.
- R9: For all legal operands, both modes give the same magnitude and sign. The magnitude is always legal BCD.
- R10: Operands and result are packed with the least significant decimal digit in bits [3:0], and each higher digit in the next 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| mode | input | 1 | 0 = nines' method, 1 = tens' method |
| a_bcd | input | 4*DIGITS | Minuend, packed BCD |
| b_bcd | input | 4*DIGITS | Subtrahend, packed BCD |
| out_valid | output | 1 | Result registers were loaded last cycle |
| diff_o | output | 4*DIGITS | Magnitude of a − b, packed BCD |
| neg_o | output | 1 | Result is negative |
| bad_o | output | 1 | An operand held an illegal digit |

## Verification
The recomplement of a carry-free sum and the rule that zero is positive act in the same cycle when equal operands are subtracted in nines' mode. In that case the sum is all nines and has no top carry, yet the result must come out as +0. Equal pairs, including 0000 and 9999, are run in both modes, and both the magnitude and the sign are judged. Another case adds the end-around carry to a sum of all zeros at the boundary 5000 − 4999. There, the carry ripples back in and must produce exactly 0001.

// File: rtl/dcs_pkg.sv
// Shared types and helpers for the decimal complement subtractor.
// Assumes 4-bit packed BCD digits.
package dcs_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic {
        SUB_NINES = 1'b0,
        SUB_TENS  = 1'b1
    } sub_mode_e;

    // Nines' complement of one digit.
    function automatic logic [DIGIT_W-1:0] nine_minus(input logic [DIGIT_W-1:0] d);
        return 4'd9 - d;
    endfunction

    // True for codes 1010..1111.
    function automatic logic is_bad_digit(input logic [DIGIT_W-1:0] d);
        return d > 4'd9;
    endfunction
endpackage

// File: rtl/dcs_digit_add.sv
// One BCD digit adder with carry in and carry out.
// Adds 6 when the binary sum exceeds 9. Assumes legal BCD inputs;
// illegal inputs give an unspecified digit.
module dcs_digit_add
    import dcs_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               cin,
    output logic [DIGIT_W-1:0] sum,
    output logic               cout
);
    logic [DIGIT_W:0] raw;

    // Binary sum and decimal correction.
    always_comb begin
        raw  = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
        cout = raw > 5'd9;
        sum  = cout ? (raw[DIGIT_W-1:0] + 4'd6) : raw[DIGIT_W-1:0];
    end

    // Check that a legal digit pair always yields a legal digit.
    always_comb begin
        if (a <= 4'd9 && b <= 4'd9) begin
            // R9
            digit_range_chk: assert (sum <= 4'd9);
        end
    end
endmodule

// File: rtl/dcs_ripple.sv
// Multi-digit BCD adder. The carry ripples from digit 0 upward.
module dcs_ripple
    import dcs_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = DIGITS * DIGIT_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [DIGITS:0] c;

    assign c[0] = cin;
    assign cout = c[DIGITS];

    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        dcs_digit_add u_add (
            .a   (x[i*DIGIT_W +: DIGIT_W]),
            .b   (y[i*DIGIT_W +: DIGIT_W]),
            .cin (c[i]),
            .sum (s[i*DIGIT_W +: DIGIT_W]),
            .cout(c[i+1])
        );
    end
endmodule

// File: rtl/dcs_nines.sv
// Digit-wise nines' complement of a packed BCD word.
module dcs_nines
    import dcs_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = DIGITS * DIGIT_W
) (
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        assign d_out[i*DIGIT_W +: DIGIT_W] = nine_minus(d_in[i*DIGIT_W +: DIGIT_W]);
    end
endmodule

// File: rtl/dec_comp_sub.sv
// Decimal complement subtractor, registered once.
// The first adder forms a + 9s(b), with carry in 1 in tens' mode.
// The second adder either adds the end-around carry (nines' mode,
// positive result) or recomplements the sum (no top carry), adding
// 1 in tens' mode. Operands are unsigned packed BCD.
module dec_comp_sub
    import dcs_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = DIGITS * DIGIT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         mode,
    input  logic [W-1:0] a_bcd,
    input  logic [W-1:0] b_bcd,
    output logic         out_valid,
    output logic [W-1:0] diff_o,
    output logic         neg_o,
    output logic         bad_o
);
    sub_mode_e    m;
    logic [W-1:0] b_nine, sum1, sum1_nine, stage2_in, mag;
    logic         c1, c2, cin2, bad_any, neg_c;

    assign m = sub_mode_e'(mode);

    dcs_nines #(.DIGITS(DIGITS)) u_bcomp (.d_in(b_bcd), .d_out(b_nine));

    dcs_ripple #(.DIGITS(DIGITS)) u_first (
        .x(a_bcd), .y(b_nine), .cin(m == SUB_TENS), .s(sum1), .cout(c1)
    );

    dcs_nines #(.DIGITS(DIGITS)) u_recomp (.d_in(sum1), .d_out(sum1_nine));

    // Pick the operand and carry in for the correction pass.
    always_comb begin
        stage2_in = c1 ? sum1 : sum1_nine;
        cin2      = (m == SUB_NINES) ? c1 : !c1;
    end

    dcs_ripple #(.DIGITS(DIGITS)) u_second (
        .x(stage2_in), .y('0), .cin(cin2), .s(mag), .cout(c2)
    );

    // Illegal digit scan and sign decision.
    always_comb begin
        bad_any = 1'b0;
        for (int i = 0; i < 2 * DIGITS; i++) begin
            if (is_bad_digit({b_bcd, a_bcd}[i*DIGIT_W +: DIGIT_W]))
                bad_any = 1'b1;
        end
        neg_c = !c1 && (mag != '0);
    end

    // The correction pass never overflows on legal operands.
    always_comb begin
        if (!bad_any) begin
            // R9
            no_wrap_chk: assert (!c2);
        end
    end

    // Result register and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            diff_o    <= '0;
            neg_o     <= 1'b0;
            bad_o     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                diff_o <= mag;
                neg_o  <= neg_c;
                bad_o  <= bad_any;
            end
        end
    end

    // R7
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R7
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(diff_o) && $stable(neg_o)));
    // R5
    zero_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !bad_o && diff_o == '0) |-> !neg_o);
endmodule

// File: tb/dec_comp_sub_tb.sv
module dec_comp_sub_tb;
    localparam int DIGITS = 4;
    localparam int W = DIGITS * 4;
    localparam int NV = 10;
    localparam logic [W-1:0] VA [NV] = '{16'h1234, 16'h1234, 16'h0000, 16'h9999, 16'h0000,
                                        16'h5000, 16'h0001, 16'h9999, 16'h4821, 16'h0500};
    localparam logic [W-1:0] VB [NV] = '{16'h1000, 16'h3000, 16'h0000, 16'h0000, 16'h9999,
                                        16'h4999, 16'h0002, 16'h9999, 16'h4821, 16'h0499};

    logic clk = 0, rst_n = 0, in_valid = 0, mode = 0;
    logic [W-1:0] a_bcd = '0, b_bcd = '0, diff_o;
    logic out_valid, neg_o, bad_o;
    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    dec_comp_sub #(.DIGITS(DIGITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .a_bcd(a_bcd), .b_bcd(b_bcd), .out_valid(out_valid),
        .diff_o(diff_o), .neg_o(neg_o), .bad_o(bad_o));

    function automatic int to_int(input logic [W-1:0] v);
        int r = 0;
        for (int i = DIGITS - 1; i >= 0; i--) r = r * 10 + int'(v[i*4 +: 4]);
        return r;
    endfunction

    function automatic logic [W-1:0] to_bcd(input int n);
        logic [W-1:0] r = '0;
        for (int i = 0; i < DIGITS; i++) begin
            r[i*4 +: 4] = 4'(n % 10);
            n = n / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic md);
        @(negedge clk);
        a_bcd = a; b_bcd = b; mode = md; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic expect_sub(input string tag, input logic [W-1:0] a, input logic [W-1:0] b, input logic md);
        int d;
        logic [W-1:0] m;
        logic n;
        run(a, b, md);
        d = to_int(a) - to_int(b);
        n = d < 0;
        m = to_bcd(n ? -d : d);
        check(out_valid && diff_o == m && neg_o == n && !bad_o, tag,
              {out_valid, bad_o, neg_o, diff_o[W-4:0]}, {1'b1, 1'b0, n, m[W-4:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check(!out_valid && diff_o == '0 && !neg_o && !bad_o, "R8", {out_valid, neg_o, bad_o, diff_o[W-4:0]}, '0);
        rst_n = 1;

        // R9 R10 table walked in both modes
        for (int i = 0; i < NV; i++) begin
            for (int md = 0; md < 2; md++) expect_sub("R9", VA[i], VB[i], 1'(md));
        end

        expect_sub("R1", 16'h1234, 16'h1000, 1'b0);
        check(diff_o == 16'h0234, "R1", diff_o, 16'h0234);
        expect_sub("R2", 16'h1234, 16'h3000, 1'b0);
        check(diff_o == 16'h1766 && neg_o, "R2", diff_o, 16'h1766);
        expect_sub("R3", 16'h1234, 16'h1000, 1'b1);
        expect_sub("R4", 16'h1234, 16'h3000, 1'b1);
        check(diff_o == 16'h1766 && neg_o, "R4", diff_o, 16'h1766);
        expect_sub("R1", 16'h5000, 16'h4999, 1'b0);
        check(diff_o == 16'h0001, "R1", diff_o, 16'h0001);

        // R5 equal operands are +0 in both modes
        run(16'h7373, 16'h7373, 1'b0);
        check(diff_o == '0 && !neg_o, "R5", {neg_o, diff_o[W-2:0]}, '0);
        run(16'h7373, 16'h7373, 1'b1);
        check(diff_o == '0 && !neg_o, "R5", {neg_o, diff_o[W-2:0]}, '0);

        // R6 illegal digits
        run(16'h12A4, 16'h0001, 1'b0);
        check(bad_o, "R6", {15'd0, bad_o}, 16'd1);
        run(16'h0001, 16'hF000, 1'b1);
        check(bad_o, "R6", {15'd0, bad_o}, 16'd1);
        run(16'h0009, 16'h9000, 1'b1);
        check(!bad_o, "R6", {15'd0, bad_o}, 16'd0);

        // R7 valid drops and result holds
        expect_sub("R7", 16'h0042, 16'h0100, 1'b0);
        @(negedge clk);
        check(!out_valid && diff_o == 16'h0058 && neg_o, "R7", {out_valid, neg_o, diff_o[W-3:0]}, {2'b01, 14'h0058});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule